// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block makes a coarse accept or reject decision for an incoming Ethernet frame from its destination address alone. The six destination address bytes arrive one per valid cycle in the order they appear on the wire. The first byte comes with a start strobe. While the bytes pass, the block runs the Ethernet CRC-32 over them. The top bits of the resulting remainder then index a 64-bit filter mask. A frame whose destination is a group (multicast) address is accepted when the indexed mask bit is set.

The decision is only a hint that the frame may be meant for this node. Software that holds the actual list of subscribed group addresses still does the exact comparison. The mask is kept in a small register bank and is loaded and read back one word at a time. After each address the block raises a single-cycle done strobe. The multicast and accept flags keep their values until the next start.

Top module: `mcast_hash_filter`

## Requirements
- R1: After the active-low reset every mask bit reads 0, and `done`, `accept` and `is_mcast` are 0.
- R2: A write with `mask_wr_en` high stores `mask_wr_data` into mask bits [k*32+31 : k*32], where k is `mask_wr_sel`. `mask_rd_data` shows the word chosen by `mask_rd_sel` combinationally.
- R3: `is_mcast` reports bit 0 of the first address byte, which is the first bit on the wire. A value of 1 marks a group address.
- R4: The CRC starts from all ones and uses polynomial 0x04C11DB7 with no final inversion. Each byte is fed least significant bit first. For each bit, the register shifts left by one and XORs in the polynomial when its old bit 31 differs from the input bit. The hash index is bits [31:26] of the remainder after all 48 bits. For a group address, `accept` equals the mask bit at that index.
- R5: When `is_mcast` is 0, `accept` is 0 whatever the mask holds.
- R6: `done` is high for exactly one cycle: the cycle after the edge that takes the sixth byte. Idle cycles between bytes of one address do not change the result.
- R7: A byte with `addr_valid` and `addr_start` high restarts the CRC and the byte count, even in the middle of an address. A valid byte with no start outside an address has no effect.
- R8: `accept` and `is_mcast` hold their decided values until the next start, and the start clears them.
- R9: The first byte of a new address may come in the cycle right after the sixth byte of the previous one. Each address then gets its own correct decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_valid | input | 1 | Address byte present this cycle |
| addr_start | input | 1 | Byte is the first of an address |
| addr_byte | input | 8 | Address byte, wire order |
| mask_wr_en | input | 1 | Mask word write enable |
| mask_wr_sel | input | 1 | Mask word written |
| mask_wr_data | input | 32 | Mask write data |
| mask_rd_sel | input | 1 | Mask word read |
| mask_rd_data | output | 32 | Selected mask word |
| done | output | 1 | Decision strobe |
| is_mcast | output | 1 | Destination is a group address |
| accept | output | 1 | Frame passes the hash filter |

## Verification
A wrong CRC bit, a lost byte or a mis-ordered bit inside a byte moves the hash index. That shows up as a wrong `accept` in the done cycle, one cycle after the sixth byte. A mask with one bit set is therefore used so that any index error becomes a reject. A byte counter that is off by one shows up at once as `done` one cycle early or late, or not at all. Stale state left from an aborted or previous address shows up in the decision for the next address, so restart and back-to-back cases are checked right at their done cycle.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   localparam int unsigned CRC_W = 32;

   // One byte through a left-shifting CRC register, byte bit 0 first.
   function automatic logic [CRC_W-1:0] crc_byte_step(
      input logic [CRC_W-1:0] cur,
      input logic [7:0]       din,
      input logic [CRC_W-1:0] poly
   );
      logic [CRC_W-1:0] r;
      r = cur;
      for (int i = 0; i < 8; i++) begin
         if (r[CRC_W-1] ^ din[i])
            r = {r[CRC_W-2:0], 1'b0} ^ poly;
         else
            r = {r[CRC_W-2:0], 1'b0};
      end
      return r;
   endfunction
endpackage

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit
   import mhf_pkg::*;
#(
   parameter logic [CRC_W-1:0] POLY = 32'h04C1_1DB7,
   parameter logic [CRC_W-1:0] SEED = 32'hFFFF_FFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             take,
   input  logic [7:0]       din,
   output logic [CRC_W-1:0] crc_next
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] base;

   // A restarting byte folds into the seed, not into stale state.
   assign base     = restart ? SEED : crc_q;
   assign crc_next = crc_byte_step(base, din, POLY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= SEED;
      else if (take)
         crc_q <= crc_next;
   end
endmodule

// File: rtl/mhf_seq.sv
module mhf_seq #(
   parameter int unsigned ADDR_BYTES = 6,
   localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic start,
   output logic first,
   output logic take,
   output logic last
);
   localparam logic [CNT_W-1:0] FULL  = CNT_W'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] PENUL = CNT_W'(ADDR_BYTES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             active;

   assign active = (cnt_q != '0) && (cnt_q != FULL);
   assign first  = valid && start;
   assign take   = valid && (start || active);

   generate
      if (ADDR_BYTES == 1) begin : g_single
         assign last = first;
      end else begin : g_multi
         assign last = valid && !start && (cnt_q == PENUL);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (first)
         cnt_q <= CNT_W'(1);
      else if (take)
         cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/mhf_mask_bank.sv
module mhf_mask_bank #(
   parameter int unsigned MASK_W = 64,
   parameter int unsigned CFG_W  = 32,
   localparam int unsigned N_WORDS = MASK_W / CFG_W,
   localparam int unsigned SEL_W   = $clog2(N_WORDS),
   localparam int unsigned IDX_W   = $clog2(MASK_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [CFG_W-1:0] wr_data,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [CFG_W-1:0] rd_data,
   input  logic [IDX_W-1:0] bit_idx,
   output logic             bit_val
);
   logic [CFG_W-1:0]  word_q [N_WORDS];
   logic [MASK_W-1:0] flat;

   generate
      for (genvar w = 0; w < N_WORDS; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q[w] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(w)))
               word_q[w] <= wr_data;
         end
         assign flat[w*CFG_W +: CFG_W] = word_q[w];
      end
   endgenerate

   assign rd_data = word_q[rd_sel];
   assign bit_val = flat[bit_idx];
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
   parameter int unsigned ADDR_BYTES = 6,
   parameter int unsigned MASK_W     = 64,
   parameter int unsigned CFG_W      = 32,
   parameter logic [31:0] POLY       = 32'h04C1_1DB7,
   parameter logic [31:0] SEED       = 32'hFFFF_FFFF,
   localparam int unsigned N_WORDS = MASK_W / CFG_W,
   localparam int unsigned SEL_W   = $clog2(N_WORDS),
   localparam int unsigned IDX_W   = $clog2(MASK_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_valid,
   input  logic             addr_start,
   input  logic [7:0]       addr_byte,
   input  logic             mask_wr_en,
   input  logic [SEL_W-1:0] mask_wr_sel,
   input  logic [CFG_W-1:0] mask_wr_data,
   input  logic [SEL_W-1:0] mask_rd_sel,
   output logic [CFG_W-1:0] mask_rd_data,
   output logic             done,
   output logic             is_mcast,
   output logic             accept
);
   import mhf_pkg::*;

   generate
      if (ADDR_BYTES < 1)
         $error("ADDR_BYTES must be at least 1");
      if ((MASK_W & (MASK_W - 1)) != 0)
         $error("MASK_W must be a power of two");
      if (MASK_W > (1 << CRC_W))
         $error("MASK_W index wider than the CRC");
      if ((MASK_W % CFG_W) != 0 || N_WORDS < 2)
         $error("MASK_W must hold two or more whole CFG_W words");
      if ((N_WORDS & (N_WORDS - 1)) != 0)
         $error("word count must be a power of two");
   endgenerate

   logic             first, take, last;
   logic [CRC_W-1:0] crc_next;
   logic [IDX_W-1:0] hash_idx;
   logic             hash_bit;
   logic             grp_q;
   logic             grp_now;
   logic             done_q, mcast_q, accept_q;

   mhf_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (addr_valid),
      .start (addr_start),
      .first (first),
      .take  (take),
      .last  (last)
   );

   mhf_crc_unit #(.POLY(POLY), .SEED(SEED)) u_crc (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (first),
      .take     (take),
      .din      (addr_byte),
      .crc_next (crc_next)
   );

   assign hash_idx = crc_next[CRC_W-1 -: IDX_W];

   mhf_mask_bank #(.MASK_W(MASK_W), .CFG_W(CFG_W)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mask_wr_en),
      .wr_sel  (mask_wr_sel),
      .wr_data (mask_wr_data),
      .rd_sel  (mask_rd_sel),
      .rd_data (mask_rd_data),
      .bit_idx (hash_idx),
      .bit_val (hash_bit)
   );

   // Group flag comes from the first wire bit of the first byte.
   assign grp_now = first ? addr_byte[0] : grp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         grp_q <= 1'b0;
      else if (first)
         grp_q <= addr_byte[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q   <= 1'b0;
         mcast_q  <= 1'b0;
         accept_q <= 1'b0;
      end else begin
         done_q <= last;
         if (last) begin
            mcast_q  <= grp_now;
            accept_q <= grp_now & hash_bit;
         end else if (first) begin
            mcast_q  <= 1'b0;
            accept_q <= 1'b0;
         end
      end
   end

   assign done     = done_q;
   assign is_mcast = mcast_q;
   assign accept   = accept_q;
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
   parameter int unsigned ADDR_BYTES = 6
) (
   input logic clk,
   input logic rst_n,
   input logic addr_valid,
   input logic addr_start,
   input logic done,
   input logic is_mcast,
   input logic accept
);
   localparam int unsigned CW = $clog2(ADDR_BYTES + 1);
   logic [CW-1:0] seen;
   logic          exp_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen     <= '0;
         exp_done <= 1'b0;
      end else begin
         exp_done <= 1'b0;
         if (addr_valid && addr_start) begin
            seen     <= CW'(1);
            exp_done <= (ADDR_BYTES == 1);
         end else if (addr_valid && seen != '0 && seen != CW'(ADDR_BYTES)) begin
            seen     <= seen + CW'(1);
            exp_done <= (seen == CW'(ADDR_BYTES - 1));
         end
      end
   end

   // R5: no acceptance of an individual address
   a_r5_unicast_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      !is_mcast |-> !accept);

   // R6: strobe lasts one cycle
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: strobe follows the sixth byte of an address
   a_r6_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
      done == exp_done);

   // R7, R8: start clears the previous decision
   a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && addr_start && ADDR_BYTES > 1) |=> (!accept && !is_mcast && !done));

   // R8: decision holds between starts except at a strobe
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(addr_valid && addr_start) |=> (done || ($stable(accept) && $stable(is_mcast))));
endmodule

bind mcast_hash_filter mhf_checker #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_valid (addr_valid),
   .addr_start (addr_start),
   .done       (done),
   .is_mcast   (is_mcast),
   .accept     (accept)
);

// File: tb/sim_mcast_hash_filter.sv
`timescale 1ns/1ps
module sim_mcast_hash_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_valid = 1'b0, addr_start = 1'b0;
   logic [7:0]  addr_byte = '0;
   logic        mask_wr_en = 1'b0;
   logic        mask_wr_sel = 1'b0;
   logic [31:0] mask_wr_data = '0;
   logic        mask_rd_sel = 1'b0;
   logic [31:0] mask_rd_data;
   logic        done, is_mcast, accept;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   mcast_hash_filter u0 (
      .clk(clk), .rst_n(rst_n),
      .addr_valid(addr_valid), .addr_start(addr_start), .addr_byte(addr_byte),
      .mask_wr_en(mask_wr_en), .mask_wr_sel(mask_wr_sel), .mask_wr_data(mask_wr_data),
      .mask_rd_sel(mask_rd_sel), .mask_rd_data(mask_rd_data),
      .done(done), .is_mcast(is_mcast), .accept(accept)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Spec model of the hash index, built from the R4 wording.
   function automatic int model_idx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int b = 0; b < 6; b++) begin
         logic [7:0] by = a[47 - 8*b -: 8];
         for (int k = 0; k < 8; k++) begin
            logic fb = c[31] ^ by[k];
            c = c << 1;
            if (fb) c = c ^ 32'h04C1_1DB7;
         end
      end
      return int'(c[31:26]);
   endfunction

   task automatic set_mask(input logic [63:0] m);
      @(negedge clk);
      mask_wr_en = 1'b1; mask_wr_sel = 1'b0; mask_wr_data = m[31:0];
      @(negedge clk);
      mask_wr_sel = 1'b1; mask_wr_data = m[63:32];
      @(negedge clk);
      mask_wr_en = 1'b0;
   endtask

   task automatic put(input logic [7:0] b, input logic st);
      @(negedge clk);
      addr_valid = 1'b1; addr_start = st; addr_byte = b;
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      addr_valid = 1'b0; addr_start = 1'b0;
   endtask

   task automatic send(input logic [47:0] a, input int gap);
      for (int i = 0; i < 6; i++) begin
         put(a[47 - 8*i -: 8], i == 0);
         if (i < 5) for (int g = 0; g < gap; g++) idle_cycle();
      end
   endtask

   // Drops valid at the cycle after the sixth byte, checks the decision there.
   task automatic expect_decision(input string req, input logic mc, input logic acc);
      idle_cycle();
      check({req, " done"}, done, 1'b1);
      check({req, " is_mcast"}, is_mcast, mc);
      check({req, " accept"}, accept, acc);
      idle_cycle();
      check({req, " done single"}, done, 1'b0);
   endtask

   task automatic t_reset();
      check("R1 done", done, 0);
      check("R1 accept", accept, 0);
      check("R1 is_mcast", is_mcast, 0);
      mask_rd_sel = 0; #1; check("R1 mask word0", mask_rd_data, 0);
      mask_rd_sel = 1; #1; check("R1 mask word1", mask_rd_data, 0);
   endtask

   task automatic t_mask_rw();
      set_mask(64'h1234_5678_A5A5_0F0F);
      mask_rd_sel = 0; #1; check("R2 read word0", mask_rd_data, 32'hA5A5_0F0F);
      mask_rd_sel = 1; #1; check("R2 read word1", mask_rd_data, 32'h1234_5678);
   endtask

   task automatic t_accept();
      logic [47:0] a = 48'h01_00_5E_00_00_01;
      set_mask(64'd1 << model_idx(a));
      send(a, 0);
      expect_decision("R3 R4 R6 accept", 1'b1, 1'b1);
   endtask

   task automatic t_reject();
      logic [47:0] a = 48'h33_33_00_00_00_01;
      set_mask(~(64'd1 << model_idx(a)));
      send(a, 0);
      expect_decision("R4 reject", 1'b1, 1'b0);
   endtask

   task automatic t_unicast();
      set_mask('1);
      send(48'h00_11_22_33_44_55, 0);
      expect_decision("R5 unicast", 1'b0, 1'b0);
   endtask

   task automatic t_gaps();
      logic [47:0] a = 48'hFF_FF_FF_FF_FF_FF;
      set_mask(64'd1 << model_idx(a));
      send(a, 2);
      expect_decision("R6 gaps", 1'b1, 1'b1);
   endtask

   task automatic t_restart();
      logic [47:0] a = 48'h01_80_C2_00_00_0E;
      set_mask(64'd1 << model_idx(a));
      put(8'h01, 1); put(8'h23, 0); put(8'h45, 0);
      send(a, 0);
      expect_decision("R7 restart", 1'b1, 1'b1);
   endtask

   task automatic t_idle_ignored();
      // Decision from the previous test is accept=1; stray bytes must not touch it.
      for (int i = 0; i < 8; i++) put(8'h00, 0);
      idle_cycle();
      check("R7 stray no done", done, 0);
      check("R8 hold accept", accept, 1'b1);
      check("R8 hold is_mcast", is_mcast, 1'b1);
   endtask

   task automatic t_b2b();
      logic [47:0] a = 48'h01_00_5E_7F_FF_FA;
      logic [47:0] b = 48'h01_00_5E_12_34_56;
      logic [63:0] m = 64'd1 << model_idx(a);
      if (model_idx(b) == model_idx(a)) b = 48'h01_00_5E_12_34_57;
      set_mask(m);
      send(a, 0);
      @(negedge clk);
      check("R9 first done", done, 1);
      check("R9 first accept", accept, 1);
      addr_valid = 1; addr_start = 1; addr_byte = b[47:40];
      for (int i = 1; i < 6; i++) put(b[47 - 8*i -: 8], 0);
      expect_decision("R9 second", 1'b1, (m >> model_idx(b)) & 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mask_rw();
      t_accept();
      t_reject();
      t_unicast();
      t_gaps();
      t_restart();
      t_idle_ignored();
      t_b2b();
      repeat (2) @(negedge clk);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule